// File: doc/BRIEF.md
# Register File with Four-Operation ALU

This block is a small datapath core: eight 8-bit general registers feeding a two-operand arithmetic and logic unit. Each register can be written from an external data input. Two read addresses pick the operands. A 2-bit opcode picks bitwise AND, bitwise OR, addition or subtraction. The 8-bit result and a carry/borrow bit are available combinationally at the outputs.

The same result can be written back into any register on the next rising clock edge. A control unit outside the block therefore sequences loads, operations and write-backs one cycle at a time. It reads results either straight from the output port or later through the operand path.

Top module: `regalu_core`

## Requirements
- R1: While `rst` is high at a rising clock edge, all eight registers become zero; reading any register afterwards returns 0x00.
- R2: When `ld_en` is high at a rising edge, the register addressed by `ld_addr` takes the value of `ld_data`.
- R3: With `op` = 2'b00, `result` is the bitwise AND of the registers addressed by `rd_a_addr` (A) and `rd_b_addr` (B).
- R4: With `op` = 2'b01, `result` is the bitwise OR of A and B.
- R5: With `op` = 2'b10, `result` is (A + B) mod 256 and `carry_out` is 1 exactly when A + B exceeds 255.
- R6: With `op` = 2'b11, `result` is (A - B) mod 256 and `carry_out` is 1 exactly when A < B (borrow).
- R7: For AND and OR, `carry_out` is 0.
- R8: When `wb_en` is high at a rising edge, the register addressed by `wb_addr` takes the current `result`.
- R9: If `ld_en` and `wb_en` are both high and `ld_addr` equals `wb_addr`, the register takes `ld_data` and the ALU result is dropped. If the two addresses differ, both writes take effect in the same edge.
- R10: A register that is not addressed by an enabled write keeps its value. With both enables low, no register changes, whatever `ld_data` and the addresses carry.
- R11: `result` and `carry_out` follow the current register contents and select inputs without a clock delay, so a value written at an edge is visible at the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, clears all registers |
| ld_en | input | 1 | External load enable |
| ld_addr | input | 3 | External load destination register |
| ld_data | input | 8 | External load value |
| rd_a_addr | input | 3 | Register read as operand A |
| rd_b_addr | input | 3 | Register read as operand B |
| op | input | 2 | Operation: 00 AND, 01 OR, 10 add, 11 subtract |
| wb_en | input | 1 | Write result back into a register |
| wb_addr | input | 3 | Write-back destination register |
| result | output | 8 | ALU result C |
| carry_out | output | 1 | Carry for add, borrow for subtract, 0 otherwise |

## Verification
The bench targets the arithmetic wrap points: 0xFF + 0x01, 0x00 - 0x01 and equal operands in subtraction. A design that takes the ninth bit from the wrong operation, or inverts the borrow, would report a carry on a clean subtraction or miss one on overflow. It drives a load and a write-back to the same register together, where a wrong priority stores the ALU value instead of the load data. It also drives two different destinations together, where a single-port design drops one of the writes. Cycles with both enables low and busy data lines catch a register that is written without an enable. Reading the same register on both ports right after a write-back catches a registered output or a stale read path.

// File: rtl/regalu_pkg.sv
package regalu_pkg;
  typedef enum logic [1:0] {
    OP_AND = 2'b00,
    OP_OR  = 2'b01,
    OP_ADD = 2'b10,
    OP_SUB = 2'b11
  } alu_op_e;
endpackage

// File: rtl/regalu_wr_arb.sv
module regalu_wr_arb #(
  parameter int N_REGS = 8,
  localparam int AW = $clog2(N_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_en,
  input  logic [AW-1:0]     ld_addr,
  input  logic              wb_en,
  input  logic [AW-1:0]     wb_addr,
  output logic [N_REGS-1:0] ld_sel,
  output logic [N_REGS-1:0] wb_sel
);
  // one write source per register; the external load wins a collision
  always_comb begin
    for (int i = 0; i < N_REGS; i++) begin
      ld_sel[i] = ld_en && (ld_addr == AW'(i));
      wb_sel[i] = wb_en && (wb_addr == AW'(i)) && !ld_sel[i];
    end
  end

  // R9
  wb_yield_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_en && wb_en && (ld_addr == wb_addr)) |-> (wb_sel == '0));

  // R9
  dual_write_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_en && wb_en && (ld_addr != wb_addr)) |-> ($countones(ld_sel | wb_sel) == 2));
endmodule

// File: rtl/regalu_regfile.sv
module regalu_regfile #(
  parameter int N_REGS = 8,
  parameter int DW     = 8,
  localparam int AW = $clog2(N_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_REGS-1:0] ld_sel,
  input  logic [N_REGS-1:0] wb_sel,
  input  logic [DW-1:0]     ld_data,
  input  logic [DW-1:0]     wb_data,
  input  logic [AW-1:0]     rd_a_addr,
  input  logic [AW-1:0]     rd_b_addr,
  output logic [DW-1:0]     rd_a,
  output logic [DW-1:0]     rd_b
);
  logic [DW-1:0] mem [N_REGS];

  for (genvar g = 0; g < N_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)            mem[g] <= '0;
      else if (ld_sel[g]) mem[g] <= ld_data;
      else if (wb_sel[g]) mem[g] <= wb_data;
    end

    // R1
    clear_chk: assert property (@(posedge clk) rst |=> (mem[g] == '0));

    // R2
    load_chk: assert property (@(posedge clk) disable iff (rst)
      ld_sel[g] |=> (mem[g] == $past(ld_data)));

    // R8
    wb_chk: assert property (@(posedge clk) disable iff (rst)
      wb_sel[g] |=> (mem[g] == $past(wb_data)));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!ld_sel[g] && !wb_sel[g]) |=> $stable(mem[g]));
  end

  assign rd_a = mem[rd_a_addr];
  assign rd_b = mem[rd_b_addr];
endmodule

// File: rtl/regalu_alu.sv
module regalu_alu
  import regalu_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] c,
  output logic          carry
);
  // ninth bit is carry for add and borrow for subtract
  function automatic logic [DW:0] alu_eval(alu_op_e f, logic [DW-1:0] x, logic [DW-1:0] y);
    case (f)
      OP_AND:  return {1'b0, x & y};
      OP_OR:   return {1'b0, x | y};
      OP_ADD:  return {1'b0, x} + {1'b0, y};
      default: return {1'b0, x} - {1'b0, y};
    endcase
  endfunction

  logic [DW:0] wide;
  assign wide  = alu_eval(op, a, b);
  assign c     = wide[DW-1:0];
  assign carry = wide[DW];
endmodule

// File: rtl/regalu_core.sv
module regalu_core
  import regalu_pkg::*;
#(
  parameter int N_REGS = 8,
  parameter int DW     = 8,
  localparam int AW = $clog2(N_REGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic [AW-1:0] rd_a_addr,
  input  logic [AW-1:0] rd_b_addr,
  input  logic [1:0]    op,
  input  logic          wb_en,
  input  logic [AW-1:0] wb_addr,
  output logic [DW-1:0] result,
  output logic          carry_out
);
  logic [N_REGS-1:0] ld_sel, wb_sel;
  logic [DW-1:0]     opnd_a, opnd_b;
  alu_op_e           op_e;

  assign op_e = alu_op_e'(op);

  regalu_wr_arb #(.N_REGS(N_REGS)) u_arb (
    .clk(clk), .rst(rst),
    .ld_en(ld_en), .ld_addr(ld_addr),
    .wb_en(wb_en), .wb_addr(wb_addr),
    .ld_sel(ld_sel), .wb_sel(wb_sel)
  );

  regalu_regfile #(.N_REGS(N_REGS), .DW(DW)) u_rf (
    .clk(clk), .rst(rst),
    .ld_sel(ld_sel), .wb_sel(wb_sel),
    .ld_data(ld_data), .wb_data(result),
    .rd_a_addr(rd_a_addr), .rd_b_addr(rd_b_addr),
    .rd_a(opnd_a), .rd_b(opnd_b)
  );

  regalu_alu #(.DW(DW)) u_alu (
    .op(op_e), .a(opnd_a), .b(opnd_b),
    .c(result), .carry(carry_out)
  );

  // R6
  borrow_chk: assert property (@(posedge clk) disable iff (rst)
    (op_e == OP_SUB) |-> (carry_out == (opnd_a < opnd_b)));

  // R7
  logic_carry_chk: assert property (@(posedge clk) disable iff (rst)
    ((op_e == OP_AND) || (op_e == OP_OR)) |-> !carry_out);

  // R5
  add_carry_chk: assert property (@(posedge clk) disable iff (rst)
    ((op_e == OP_ADD) && carry_out) |-> (result < opnd_a));
endmodule

// File: tb/test_regalu_core.sv
`timescale 1ns/1ps
module test_regalu_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ld_en = 1'b0, wb_en = 1'b0;
  logic [2:0] ld_addr = '0, wb_addr = '0, rd_a_addr = '0, rd_b_addr = '0;
  logic [7:0] ld_data = '0;
  logic [1:0] op = 2'b00;
  logic [7:0] result;
  logic       carry_out;

  int model [8];
  int n_checks = 0, n_errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  regalu_core i_regalu_core (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_a_addr(rd_a_addr), .rd_b_addr(rd_b_addr), .op(op),
    .wb_en(wb_en), .wb_addr(wb_addr), .result(result), .carry_out(carry_out)
  );

  function automatic int exp_res(int a, int b, int f);
    if (f == 0) return a & b;
    if (f == 1) return a | b;
    if (f == 2) return (a + b) % 256;
    return (a - b + 256) % 256;
  endfunction

  function automatic int exp_cy(int a, int b, int f);
    if (f == 2) return (a + b > 255) ? 1 : 0;
    if (f == 3) return (a < b) ? 1 : 0;
    return 0;
  endfunction

  // inputs are set at the falling edge; check mid-cycle, then update the model at the rising edge
  task automatic tick(string tag);
    int a, b, f, er, ec;
    #1;
    a = model[rd_a_addr]; b = model[rd_b_addr]; f = int'(op);
    er = exp_res(a, b, f); ec = exp_cy(a, b, f);
    if (!rst) begin
      n_checks++;
      if (int'(result) != er || int'(carry_out) != ec) begin
        n_errors++;
        $display("FAIL %s: result=%02h carry=%0d expected result=%02h carry=%0d",
                 tag, result, carry_out, er[7:0], ec);
      end
    end
    @(posedge clk);
    if (rst) foreach (model[i]) model[i] = 0;
    else begin
      if (wb_en) model[wb_addr] = er;
      if (ld_en) model[ld_addr] = int'(ld_data);
    end
    @(negedge clk);
  endtask

  task automatic scan(string tag);
    ld_en = 0; wb_en = 0; op = 2'b01;
    for (int i = 0; i < 8; i++) begin
      rd_a_addr = 3'(i); rd_b_addr = 3'(i);
      tick(tag);
    end
  endtask

  task automatic load(int r, int v);
    ld_en = 1; ld_addr = 3'(r); ld_data = 8'(v); wb_en = 0;
    tick("R2");
    ld_en = 0;
  endtask

  task automatic run_op(int ra, int rb, int f, string tag);
    rd_a_addr = 3'(ra); rd_b_addr = 3'(rb); op = 2'(f);
    tick(tag);
  endtask

  initial begin
    @(negedge clk);
    tick("R1"); tick("R1");
    rst = 0;
    scan("R1");
    // R2: fill every register
    for (int i = 0; i < 8; i++) load(i, 16 * i + 3);
    scan("R2");
    load(0, 8'hFF); load(1, 8'h01); load(2, 8'h00); load(3, 8'hA5); load(4, 8'h5A);
    run_op(3, 4, 0, "R3"); run_op(0, 3, 0, "R3");
    run_op(3, 4, 1, "R4"); run_op(2, 2, 1, "R4");
    run_op(0, 1, 2, "R5"); run_op(3, 4, 2, "R5"); run_op(0, 0, 2, "R5");
    run_op(2, 1, 3, "R6"); run_op(3, 3, 3, "R6"); run_op(0, 1, 3, "R6");
    run_op(0, 0, 0, "R7"); run_op(0, 0, 1, "R7");
    // R8: write back 0xFF+0x01 into r5, then read it next cycle (R11)
    wb_en = 1; wb_addr = 3'd5; run_op(0, 1, 2, "R8"); wb_en = 0;
    run_op(5, 5, 1, "R11");
    wb_en = 1; wb_addr = 3'd6; run_op(3, 4, 1, "R8"); wb_en = 0;
    run_op(6, 6, 1, "R11");
    // R9: collision on r7, load must win
    ld_en = 1; ld_addr = 3'd7; ld_data = 8'h3C; wb_en = 1; wb_addr = 3'd7;
    run_op(3, 4, 2, "R9");
    ld_en = 0; wb_en = 0; run_op(7, 7, 1, "R9");
    // R9: different destinations both land
    ld_en = 1; ld_addr = 3'd1; ld_data = 8'h77; wb_en = 1; wb_addr = 3'd2;
    run_op(3, 4, 3, "R9");
    scan("R9");
    // R10: both enables low, busy data lines
    for (int k = 0; k < 4; k++) begin
      ld_en = 0; wb_en = 0; ld_data = 8'(8'hC3 + k); ld_addr = 3'(k); wb_addr = 3'(k + 2);
      run_op(k, k + 1, 2, "R10");
    end
    scan("R10");
    // mixed traffic against the model
    for (int k = 0; k < 400; k++) begin
      ld_en = 1'($urandom_range(0, 1)); wb_en = 1'($urandom_range(0, 1));
      ld_addr = 3'($urandom); wb_addr = 3'($urandom); ld_data = 8'($urandom);
      run_op(int'($urandom_range(0, 7)), int'($urandom_range(0, 7)),
             int'($urandom_range(0, 3)), "R11");
    end
    // R1: reset in mid-run clears everything
    rst = 1; tick("R1"); rst = 0;
    scan("R1");
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule